// File: doc/BRIEF.md
# EDO DRAM Control Model

This block is a synthesizable behavioural model of the control logic inside an extended-data-out DRAM. A fast internal clock samples the active-low row strobe, column strobe, write enable and output enable, and the multiplexed address. The model latches a row on the row strobe's falling edge and a column on each column strobe's falling edge. It reads and writes a small array whose depth is set by parameters. Read data sits in an output latch that keeps driving after the column strobe rises, as EDO page mode requires. Separate rules decide when the tri-state data bus is enabled.

A column-strobe-first sequence is detected and starts a refresh cycle. That cycle takes its row from an internal 9-bit refresh counter. Further column cycles inside it access the array at the counter row, which lets a bench check the counter. Every row-strobe cycle refreshes one row. A per-row age counter raises a flag when any row has gone unrefreshed for a programmable number of clocks. The model gives a memory-controller testbench a target whose behaviour it can check.

Top module: `edo_dram_model`

## Requirements
- R1: A row strobe fall that finds the column strobe low, with a column strobe fall seen while the row strobe was high and no column strobe rise since, starts a refresh cycle. That cycle uses the refresh counter's low ROW_BITS bits as its row and ignores addr_i.
- R2: During a refresh cycle, dq_oe_o stays 0 until a column access takes place inside it.
- R3: A column strobe fall while the row strobe is high writes nothing and leaves the output latch and dq_oe_o unchanged.
- R4: Inside an open row cycle, a column strobe fall with we_ni high reads the cell at (row, addr_i[COL_BITS-1:0]) into the output latch. The latch keeps driving dq_o with dq_oe_o=1 after the column strobe rises, while the row strobe stays low.
- R5: The output latch is released, and dq_oe_o falls to 0, only at the first clock where both the row strobe and the column strobe are high, whichever of them rose last.
- R6: oe_ni high forces dq_oe_o to 0 without changing dq_o. we_ni low while cas_ni is low also forces dq_oe_o to 0.
- R7: Write data is taken from dq_i at the later of the column strobe fall and the write enable fall. Changes on dq_i after that clock are not stored.
- R8: Every row strobe fall outside a refresh cycle refreshes row addr_i[ROW_BITS-1:0].
- R9: Column cycles inside a refresh cycle read or write the array at the row given by the refresh counter.
- R10: The refresh counter starts at 0 and steps by one, modulo 512, when the row strobe rises at the end of each refresh cycle.
- R11: stale_o is 1 when some row has gone REFRESH_LIMIT or more clocks since its last refresh, or since reset, and 0 otherwise.
- R12: After reset, dq_oe_o and stale_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | DATA_W | Write data from the bus |
| dq_o | output | DATA_W | Output latch contents |
| dq_oe_o | output | 1 | Data bus driver enable |
| stale_o | output | 1 | Some row exceeded the refresh interval |

## Verification
The assertions assume the strobes are synchronous to clk_i and that every level is held for at least one clock. They also assume a column strobe never falls in the same clock as the row strobe falls, so that each edge is seen alone and in order. The bench changes pins only on the falling clock edge, one strobe step per clock. It holds the row strobe low for one extra clock before the first column strobe fall, so every edge it makes falls inside those assumptions.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_ROW,
    CYC_CBR
  } cyc_e;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output logic ras_fall_o,
  output logic ras_rise_o,
  output logic ras_held_o,
  output logic cas_fall_o,
  output logic cas_rise_o,
  output logic we_fall_o
);
  logic ras_q, cas_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_ni;
      cas_q <= cas_ni;
      we_q  <= we_ni;
    end
  end

  assign ras_fall_o = ras_q & ~ras_ni;
  assign ras_rise_o = ~ras_q & ras_ni;
  assign ras_held_o = ~ras_q & ~ras_ni;
  assign cas_fall_o = cas_q & ~cas_ni;
  assign cas_rise_o = ~cas_q & cas_ni;
  assign we_fall_o  = we_q & ~we_ni;
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 8
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic [ROW_BITS-1:0] row_i,
  input  logic [COL_BITS-1:0] wcol_i,
  input  logic [COL_BITS-1:0] rcol_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[{row_i, wcol_i}] <= wdata_i;
  end

  assign rdata_o = mem_q[{row_i, rcol_i}];
endmodule

// File: rtl/edo_refresh_tracker.sv
module edo_refresh_tracker #(
  parameter int ROW_BITS      = 3,
  parameter int CNT_W         = 9,
  parameter int REFRESH_LIMIT = 4096
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic                touch_i,
  input  logic [ROW_BITS-1:0] touch_row_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                stale_o
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int AGE_W = $clog2(REFRESH_LIMIT + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(REFRESH_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [ROWS-1:0]  row_stale;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end
  assign cnt_o = cnt_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     age_q <= '0;
      else if (touch_i && touch_row_i == ROW_BITS'(r)) age_q <= '0;
      else if (age_q != AGE_MAX)                       age_q <= age_q + 1'b1;
    end
    assign row_stale[r] = (age_q == AGE_MAX);
  end

  assign stale_o = |row_stale;

  // R10: one step per completed refresh cycle, wrapping at the counter width
  a_r10_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  a_r10_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
  import edo_pkg::*;
#(
  parameter int ADDR_W        = 9,
  parameter int ROW_BITS      = 3,
  parameter int COL_BITS      = 3,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 9,
  parameter int REFRESH_LIMIT = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              stale_o
);
  logic ras_fall, ras_rise, ras_held, cas_fall, cas_rise, we_fall;

  edo_strobe_edges i_edges (
    .clk_i, .rst_ni, .ras_ni, .cas_ni, .we_ni,
    .ras_fall_o(ras_fall), .ras_rise_o(ras_rise), .ras_held_o(ras_held),
    .cas_fall_o(cas_fall), .cas_rise_o(cas_rise), .we_fall_o(we_fall)
  );

  cyc_e                cyc_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;
  logic                col_open_q, armed_q, out_valid_q, cbr_io_q;
  logic [DATA_W-1:0]   dout_q, rdata;
  logic [CNT_W-1:0]    cnt;

  logic cbr_start, col_access, rd, wr;
  logic [COL_BITS-1:0] acc_col;
  logic [ROW_BITS-1:0] start_row;
  logic pins_unused;

  assign cbr_start  = ras_fall & armed_q & ~cas_ni;
  assign col_access = cas_fall & ras_held & (cyc_q != CYC_IDLE);
  assign acc_col    = col_access ? addr_i[COL_BITS-1:0] : col_q;
  assign rd         = col_access & we_ni;
  // later of the two falling edges launches the write
  assign wr = (col_access & ~we_ni) |
              (we_fall & ~cas_ni & ras_held & col_open_q & ~col_access);
  assign start_row  = cbr_start ? cnt[ROW_BITS-1:0] : addr_i[ROW_BITS-1:0];
  assign pins_unused = ^{addr_i, cnt};

  edo_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) i_array (
    .clk_i, .we_i(wr), .row_i(row_q), .wcol_i(acc_col), .rcol_i(acc_col),
    .wdata_i(dq_i), .rdata_o(rdata)
  );

  edo_refresh_tracker #(.ROW_BITS(ROW_BITS), .CNT_W(CNT_W), .REFRESH_LIMIT(REFRESH_LIMIT)) i_refresh (
    .clk_i, .rst_ni,
    .step_i(ras_rise && cyc_q == CYC_CBR),
    .touch_i(ras_fall), .touch_row_i(start_row),
    .cnt_o(cnt), .stale_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q       <= CYC_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      col_open_q  <= 1'b0;
      armed_q     <= 1'b0;
      out_valid_q <= 1'b0;
      cbr_io_q    <= 1'b0;
      dout_q      <= '0;
    end else begin
      if (ras_fall) begin
        cyc_q <= cbr_start ? CYC_CBR : CYC_ROW;
        row_q <= start_row;
      end else if (ras_rise) begin
        cyc_q <= CYC_IDLE;
      end

      if (ras_fall)                armed_q <= 1'b0;
      else if (cas_fall && ras_ni) armed_q <= 1'b1;
      else if (cas_rise)           armed_q <= 1'b0;

      if (col_access) begin
        col_q      <= addr_i[COL_BITS-1:0];
        col_open_q <= 1'b1;
      end else if (cas_rise || ras_ni) begin
        col_open_q <= 1'b0;
      end

      if (col_access && cyc_q == CYC_CBR) cbr_io_q <= 1'b1;
      else if (ras_rise)                  cbr_io_q <= 1'b0;

      if (ras_ni && cas_ni)     out_valid_q <= 1'b0;
      else if (cbr_start || wr) out_valid_q <= 1'b0;
      else if (rd)              out_valid_q <= 1'b1;

      if (rd) dout_q <= rdata;
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = out_valid_q & ~oe_ni & ~(~we_ni & ~cas_ni);

  // R1: refresh cycle row comes from the counter
  a_r1_cbr_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_start |=> (row_q == $past(cnt[ROW_BITS-1:0])));
  // R2: refresh-only cycle keeps the bus released
  a_r2_cbr_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_CBR && !cbr_io_q) |-> !dq_oe_o);
  // R3: column strobe with row strobe high leaves the latch alone
  a_r3_latch_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_ni && cas_fall) |=> $stable(dout_q));
  // R5: both strobes high releases the bus one clock later
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_ni && cas_ni) |=> !dq_oe_o);
endmodule

// File: tb/test_edo_dram_model.sv
`timescale 1ns/1ps
module test_edo_dram_model;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dq_oe, stale;

  int checks = 0;
  int fails  = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  edo_dram_model #(.REFRESH_LIMIT(64)) i_edo_dram_model (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .dq_i(din), .dq_o(dout), .dq_oe_o(dq_oe),
    .stale_o(stale)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic r, input logic c, input logic w, input logic o,
                      input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic ras_open(input int row);
    tick(0, 1, 1, 0, 9'(row), 8'h00);
    tick(0, 1, 1, 0, 9'(row), 8'h00);
  endtask

  task automatic ras_close();
    tick(0, 1, 1, 0, 9'h0, 8'h00);
    tick(1, 1, 1, 0, 9'h0, 8'h00);
  endtask

  task automatic early_write(input int col, input logic [7:0] d);
    tick(0, 0, 0, 0, 9'(col), d);
    check("R6 early write bus off", 32'(dq_oe), 32'd0);
    tick(0, 1, 1, 0, 9'(col), d);
  endtask

  task automatic read_chk(input int col, input logic [7:0] exp, input string req);
    tick(0, 0, 1, 0, 9'(col), 8'h00);
    check({req, " read oe"}, 32'(dq_oe), 32'd1);
    check({req, " read data"}, 32'(dout), 32'(exp));
    tick(0, 1, 1, 0, 9'(col), 8'h00);
    check("R4 edo hold oe", 32'(dq_oe), 32'd1);
    check("R4 edo hold data", 32'(dout), 32'(exp));
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R12 reset oe", 32'(dq_oe), 32'd0);
    check("R12 reset stale", 32'(stale), 32'd0);
  endtask

  task automatic t_fill();
    for (int r = 0; r < 8; r++) begin
      ras_open(r);
      early_write(0, 8'h10 + 8'(r));
      ras_close();
    end
    ras_open(2);
    for (int c = 0; c < 4; c++) early_write(c, 8'hA0 + 8'(c));
    ras_close();
  endtask

  task automatic t_page_read();
    ras_open(2);
    for (int c = 3; c >= 0; c--) read_chk(c, 8'hA0 + 8'(c), "R4 page");
    ras_close();
    check("R5 released after close", 32'(dq_oe), 32'd0);
  endtask

  task automatic t_release_order();
    ras_open(4);
    tick(0, 0, 1, 0, 9'h0, 8'h00);
    check("R4 row4 read", 32'(dout), 32'h14);
    tick(1, 0, 1, 0, 9'h0, 8'h00);
    check("R5 ras high cas low keeps bus", 32'(dq_oe), 32'd1);
    tick(1, 1, 1, 0, 9'h0, 8'h00);
    check("R5 both high releases", 32'(dq_oe), 32'd0);
  endtask

  task automatic t_oe_gate();
    ras_open(2);
    tick(0, 0, 1, 0, 9'h2, 8'h00);
    check("R6 read on", 32'(dq_oe), 32'd1);
    tick(0, 0, 1, 1, 9'h2, 8'h00);
    check("R6 oe high off", 32'(dq_oe), 32'd0);
    check("R6 oe high data kept", 32'(dout), 32'hA2);
    tick(0, 0, 1, 0, 9'h2, 8'h00);
    check("R6 oe low on again", 32'(dq_oe), 32'd1);
    check("R6 data unchanged", 32'(dout), 32'hA2);
    tick(0, 1, 1, 0, 9'h2, 8'h00);
    ras_close();
  endtask

  task automatic t_late_write();
    ras_open(2);
    tick(0, 0, 1, 0, 9'h1, 8'h00);
    check("R7 rmw old data", 32'(dout), 32'hA1);
    tick(0, 0, 0, 0, 9'h1, 8'h3C);
    check("R6 we low cas low off", 32'(dq_oe), 32'd0);
    tick(0, 0, 0, 0, 9'h1, 8'hFF);
    tick(0, 1, 1, 0, 9'h1, 8'hFF);
    ras_close();
    ras_open(2);
    read_chk(1, 8'h3C, "R7 late write");
    ras_close();
  endtask

  task automatic t_cas_ras_high();
    tick(1, 0, 0, 0, 9'h3, 8'hEE);
    check("R3 cas with ras high bus", 32'(dq_oe), 32'd0);
    tick(1, 1, 1, 0, 9'h3, 8'hEE);
    check("R3 latch untouched", 32'(dout), 32'h3C);
    ras_open(2);
    read_chk(3, 8'hA3, "R3 no write");
    ras_close();
  endtask

  task automatic cbr(input bit acc, input bit wr, input int col,
                     input logic [7:0] d, input logic [7:0] expd, input string req);
    tick(1, 0, 1, 0, 9'h0, 8'h00);
    check("R2 pre entry bus", 32'(dq_oe), 32'd0);
    tick(0, 0, 1, 0, 9'h005, 8'h00);
    check("R2 entry bus", 32'(dq_oe), 32'd0);
    tick(0, 0, 1, 0, 9'h005, 8'h00);
    check("R2 refresh bus", 32'(dq_oe), 32'd0);
    if (acc) begin
      tick(0, 1, 1, 0, 9'h005, 8'h00);
      check("R2 refresh bus after cas", 32'(dq_oe), 32'd0);
      tick(0, 0, wr ? 1'b0 : 1'b1, wr ? 1'b1 : 1'b0, 9'(col), d);
      if (!wr) begin
        check({req, " oe"}, 32'(dq_oe), 32'd1);
        check({req, " data"}, 32'(dout), 32'(expd));
      end
    end
    tick(0, 1, 1, 0, 9'h0, 8'h00);
    tick(1, 1, 1, 0, 9'h0, 8'h00);
    check("R5 after refresh", 32'(dq_oe), 32'd0);
    exp_cnt++;
  endtask

  task automatic t_refresh_counter();
    cbr(0, 0, 0, 8'h00, 8'h00, "R2");
    cbr(1, 0, 0, 8'h00, 8'h10 + 8'(exp_cnt % 8), "R1 R9 R10 counter row");
    cbr(1, 1, 5, 8'h5C, 8'h00, "R9 write");
    ras_open(2);
    read_chk(5, 8'h5C, "R9 counter write lands");
    ras_close();
    cbr(1, 0, 0, 8'h00, 8'h10 + 8'(exp_cnt % 8), "R10 next row");
  endtask

  task automatic t_stale();
    for (int r = 0; r < 8; r++) begin
      tick(0, 1, 1, 0, 9'(r), 8'h00);
      tick(1, 1, 1, 0, 9'(r), 8'h00);
    end
    check("R11 all fresh", 32'(stale), 32'd0);
    repeat (80) tick(1, 1, 1, 0, 9'h0, 8'h00);
    check("R11 stale after limit", 32'(stale), 32'd1);
    for (int r = 0; r < 7; r++) begin
      tick(0, 1, 1, 0, 9'(r) | 9'h100, 8'h00);
      tick(1, 1, 1, 0, 9'h0, 8'h00);
    end
    check("R8 row7 still stale", 32'(stale), 32'd1);
    tick(0, 1, 1, 0, 9'h107, 8'h00);
    tick(1, 1, 1, 0, 9'h0, 8'h00);
    check("R8 ras only refresh", 32'(stale), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_page_read();
    t_release_order();
    t_oe_gate();
    t_late_write();
    t_cas_ras_high();
    t_refresh_counter();
    t_stale();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule